// File: doc/BRIEF.md
# Flash Byte-Program Command Interface

This block is a cycle-based model of the command front end of a byte-wide NOR flash device. A host issues bus write cycles (address, data, write strobe) to enter commands and presents an address to read. The interface moves between four modes: array read, status read, program setup and programming. A byte is programmed with two write cycles. The first carries a setup code. The second carries the target address and the data. An internal engine then runs for a fixed number of clock cycles and commits the result to a small on-chip byte array.

Programming can only turn bits from 1 to 0. The stored value becomes the old value ANDed with the written data. The status byte keeps three separate causes of failure: program voltage too low, a locked boot region, and a verify miss. Three level inputs report the state of the device pins: the program-voltage level, the high-voltage unlock level and the write-protect level. All error bits are sticky until the host clears them with a command.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the interface is in array-read mode, every array byte reads 0xFF, and the status byte reads 0x80.
- R2: A write takes effect once, on the clock where `bus_we` is first seen high after being low. Holding `bus_we` high for more cycles does not issue a second write.
- R3: A first write of 0x40, or of the alternate code 0x10, enters program setup. The next write supplies the target address and the data.
- R4: While programming, every read returns the status byte with bit 7 equal to 0. This lasts for exactly PROG_CYCLES clock cycles after the second write. After that, bit 7 reads 1.
- R5: Writes that arrive while programming is in progress are ignored. This includes a write on the cycle in which programming completes.
- R6: The programmed byte becomes old AND data. After a program attempt, reads keep returning the status byte until another command is written.
- R7: If the data has a 1 in a bit where the old byte has a 0, status bit 4 (program failure) is set.
- R8: If `vpp_ok` is low when the second write arrives, status bits 3 and 4 are set, the array is unchanged, and no busy period occurs. This check takes precedence over the boot-region check.
- R9: A target address below BOOT_BYTES, with `wp_n` low and `unlock_hv` low, sets status bits 1 and 4 and leaves the array unchanged. If either `wp_n` or `unlock_hv` is high, the byte programs normally.
- R10: Code 0x50 clears status bits 4, 3 and 1 and does not change the mode. Error bits otherwise persist, including across later successful programs.
- R11: Code 0xFF selects array reads and 0x70 selects status reads. Any other code written in those modes has no effect. Status bits 6, 5, 2 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Address for both read and write cycles |
| bus_wdata | input | 8 | Write data or command code |
| bus_we | input | 1 | Write strobe, active high; its rising edge accepts a write |
| vpp_ok | input | 1 | High when the program voltage is above the lockout level |
| unlock_hv | input | 1 | High when the reset/unlock pin is at its high-voltage level |
| wp_n | input | 1 | Write-protect level; low protects the boot region |
| bus_rdata | output | 8 | Array byte in array mode, status byte in all other modes |

## Verification
A bus write strobe edge can land on the same clock as the engine's completion. In that cycle the array commit and the status update happen while a new command is also presented. The bench provokes this by starting a program that is bound to fail verify. It then times a clear-status write so that its strobe edge is sampled exactly on the completion clock. The result is judged correct if the failure bit is still set and the byte holds old AND data, which shows the commit happened and the write was dropped. A later clear then takes effect normally.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_STATUS = 2'd1,
        MODE_SETUP  = 2'd2,
        MODE_BUSY   = 2'd3
    } mode_t;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_SETUP  = 3'd1,
        CMD_CLEAR  = 3'd2,
        CMD_ARRAY  = 3'd3,
        CMD_STATUS = 3'd4
    } cmd_t;

    localparam logic [7:0] CODE_SETUP     = 8'h40;
    localparam logic [7:0] CODE_SETUP_ALT = 8'h10;
    localparam logic [7:0] CODE_CLEAR     = 8'h50;
    localparam logic [7:0] CODE_ARRAY     = 8'hFF;
    localparam logic [7:0] CODE_STATUS    = 8'h70;

    localparam int SR_READY = 7;
    localparam int SR_FAIL  = 4;
    localparam int SR_VOLT  = 3;
    localparam int SR_LOCK  = 1;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_t       kind
);
    always_comb begin
        unique case (code)
            CODE_SETUP, CODE_SETUP_ALT: kind = CMD_SETUP;
            CODE_CLEAR:                 kind = CMD_CLEAR;
            CODE_ARRAY:                 kind = CMD_ARRAY;
            CODE_STATUS:                kind = CMD_STATUS;
            default:                    kind = CMD_NONE;
        endcase
    end
endmodule

// File: rtl/flash_prog_timer.sv
module flash_prog_timer #(
    parameter int CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d  = t_q;
        done = t_q.run && (t_q.cnt == '0);
        if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = CNT_W'(CYCLES - 1);
        end else if (t_q.run) begin
            if (done) begin
                t_d.run = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy = t_q.run;

    AST_TMR_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !t_q.run); // R4

    AST_TMR_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !t_q.run); // R4
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [7:0]        rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [7:0]        rd_data_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data
);
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_a = mem_q[rd_addr_a];
    assign rd_data_b = mem_q[rd_addr_b];

    AST_NO_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_data & ~mem_q[wr_addr]) == 8'h00)); // R6
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_cmd_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int BOOT_BYTES  = 8,
    parameter int PROG_CYCLES = 5,
    parameter int ADDR_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    input  logic              vpp_ok,
    input  logic              unlock_hv,
    input  logic              wp_n,
    output logic [7:0]        bus_rdata
);
    typedef struct packed {
        mode_t             mode;
        logic              we_q;
        logic              err_fail;
        logic              err_volt;
        logic              err_lock;
        logic [ADDR_W-1:0] tgt_addr;
        logic [7:0]        tgt_data;
    } ctl_t;

    ctl_t s_d, s_q;

    cmd_t       cmd_kind;
    logic       wr_edge;
    logic       boot_hit;
    logic       clr_hit;
    logic       tmr_start, tmr_busy, tmr_done;
    logic       arr_wr;
    logic [7:0] arr_wdata;
    logic [7:0] arr_rd_bus;
    logic [7:0] arr_rd_old;
    logic [7:0] status_byte;

    flash_cmd_decode u_decode (
        .code (bus_wdata),
        .kind (cmd_kind)
    );

    flash_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    flash_byte_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_a (bus_addr),
        .rd_data_a (arr_rd_bus),
        .rd_addr_b (s_q.tgt_addr),
        .rd_data_b (arr_rd_old),
        .wr_en     (arr_wr),
        .wr_addr   (s_q.tgt_addr),
        .wr_data   (arr_wdata)
    );

    assign wr_edge  = bus_we && !s_q.we_q;
    assign boot_hit = int'(bus_addr) < BOOT_BYTES;

    always_comb begin
        s_d       = s_q;
        s_d.we_q  = bus_we;
        tmr_start = 1'b0;
        arr_wr    = 1'b0;
        arr_wdata = arr_rd_old & s_q.tgt_data;
        clr_hit   = 1'b0;
        unique case (s_q.mode)
            MODE_BUSY: begin
                if (tmr_done) begin
                    arr_wr   = 1'b1;
                    s_d.mode = MODE_STATUS;
                    if ((s_q.tgt_data & ~arr_rd_old) != 8'h00) begin
                        s_d.err_fail = 1'b1;
                    end
                end
            end
            MODE_SETUP: begin
                if (wr_edge) begin
                    s_d.mode = MODE_STATUS;
                    if (!vpp_ok) begin
                        s_d.err_volt = 1'b1;
                        s_d.err_fail = 1'b1;
                    end else if (boot_hit && !wp_n && !unlock_hv) begin
                        s_d.err_lock = 1'b1;
                        s_d.err_fail = 1'b1;
                    end else begin
                        s_d.tgt_addr = bus_addr;
                        s_d.tgt_data = bus_wdata;
                        s_d.mode     = MODE_BUSY;
                        tmr_start    = 1'b1;
                    end
                end
            end
            default: begin
                if (wr_edge) begin
                    unique case (cmd_kind)
                        CMD_SETUP:  s_d.mode = MODE_SETUP;
                        CMD_ARRAY:  s_d.mode = MODE_ARRAY;
                        CMD_STATUS: s_d.mode = MODE_STATUS;
                        CMD_CLEAR: begin
                            clr_hit      = 1'b1;
                            s_d.err_fail = 1'b0;
                            s_d.err_volt = 1'b0;
                            s_d.err_lock = 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= MODE_ARRAY;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        status_byte           = 8'h00;
        status_byte[SR_READY] = (s_q.mode != MODE_BUSY);
        status_byte[SR_FAIL]  = s_q.err_fail;
        status_byte[SR_VOLT]  = s_q.err_volt;
        status_byte[SR_LOCK]  = s_q.err_lock;
    end

    assign bus_rdata = (s_q.mode == MODE_ARRAY) ? arr_rd_bus : status_byte;

    AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_BUSY) == tmr_busy); // R4

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_BUSY && !tmr_done) |=> (s_q.mode == MODE_BUSY)); // R5

    AST_VOLT_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_SETUP && wr_edge && !vpp_ok)
        |=> (!tmr_busy && s_q.err_volt)); // R8

    AST_LOCK_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_SETUP && wr_edge && vpp_ok && boot_hit && !wp_n && !unlock_hv)
        |=> (!tmr_busy && s_q.err_lock)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err_fail && !clr_hit) |=> s_q.err_fail); // R10

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode != MODE_ARRAY) |-> (bus_rdata[6:5] == 2'b00 && !bus_rdata[2] && !bus_rdata[0])); // R11
endmodule

// File: tb/flash_cmd_if_bench.sv
module flash_cmd_if_bench;
    localparam int DEPTH = 64;
    localparam int BOOT  = 8;
    localparam int PC    = 5;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic          vpp_ok = 1'b1;
    logic          unlock_hv = 1'b0;
    logic          wp_n = 1'b1;
    logic [7:0]    bus_rdata;

    int   errs = 0;
    int   checks = 0;
    logic [7:0] ref_mem [DEPTH];
    bit   r_fail, r_volt, r_lock;

    always #5 clk = ~clk;

    flash_cmd_if #(.DEPTH(DEPTH), .BOOT_BYTES(BOOT), .PROG_CYCLES(PC)) u_flash_cmd_if (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .vpp_ok(vpp_ok), .unlock_hv(unlock_hv), .wp_n(wp_n),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] exp_sr();
        return {1'b1, 2'b00, r_fail, r_volt, 1'b0, r_lock, 1'b0};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic busy_count(output int n);
        n = 0;
        #1;
        while (!bus_rdata[7] && n < 100) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic chk_arr(input logic [AW-1:0] a, input string tag);
        logic [7:0] v;
        wr(0, 8'hFF);
        rd(a, v);
        check(tag, v, ref_mem[a]);
    endtask

    task automatic chk_sr(input string tag);
        logic [7:0] v;
        rd(6'd17, v);
        check(tag, v, exp_sr());
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d, input bit vpp,
                        input bit wpn, input bit unl, input logic [7:0] code, input string tag);
        int n;
        int eb;
        vpp_ok = vpp; wp_n = wpn; unlock_hv = unl;
        wr(a, code);
        wr(a, d);
        eb = 0;
        if (!vpp) begin
            r_volt = 1; r_fail = 1;
        end else if (int'(a) < BOOT && !wpn && !unl) begin
            r_lock = 1; r_fail = 1;
        end else begin
            eb = PC;
            if ((d & ~ref_mem[a]) != 8'h00) r_fail = 1;
            ref_mem[a] = ref_mem[a] & d;
        end
        busy_count(n);
        check({tag, " R4 busy cycles"}, n, eb);
        chk_sr({tag, " status"});
        vpp_ok = 1'b1; wp_n = 1'b1; unlock_hv = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
    end

    initial begin
        logic [7:0] v;
        int n;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        r_fail = 0; r_volt = 0; r_lock = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(0, v);  check("R1 array byte 0 after reset", v, 8'hFF);
        rd(63, v); check("R1 array byte 63 after reset", v, 8'hFF);
        wr(0, 8'h70);
        rd(0, v);  check("R1 R11 status after reset", v, 8'h80);

        // R2: held strobe is one write
        @(negedge clk);
        bus_addr = 5; bus_wdata = 8'h40; bus_we = 1'b1;
        repeat (3) @(negedge clk);
        bus_we = 1'b0;
        wr(5, 8'h0F);
        ref_mem[5] = 8'h0F;
        busy_count(n);
        check("R2 held strobe then data busy", n, PC);
        chk_arr(5, "R2 byte after held strobe");

        // R3: alternate setup code
        prog(20, 8'hA5, 1, 1, 0, 8'h10, "R3 alt code");
        chk_arr(20, "R3 byte after alt code");

        // R6: AND result, status mode persists
        prog(20, 8'h81, 1, 1, 0, 8'h40, "R6 clean and");
        rd(20, v); check("R6 read stays status", v, exp_sr());
        chk_arr(20, "R6 byte is and");

        // R7: verify failure
        prog(20, 8'h0F, 1, 1, 0, 8'h40, "R7 verify miss");
        check("R7 fail bit", {31'd0, r_fail}, 1);
        chk_arr(20, "R7 byte still and");
        // R10: sticky then cleared
        prog(21, 8'hF0, 1, 1, 0, 8'h40, "R10 later good program");
        wr(0, 8'h50); r_fail = 0; r_volt = 0; r_lock = 0;
        chk_sr("R10 cleared status");

        // R8: voltage low
        prog(30, 8'h00, 0, 1, 0, 8'h40, "R8 vpp low");
        chk_arr(30, "R8 byte unchanged");
        wr(0, 8'h50); r_fail = 0; r_volt = 0; r_lock = 0;

        // R9: boot region lock
        prog(2, 8'h00, 1, 0, 0, 8'h40, "R9 locked boot");
        chk_arr(2, "R9 byte unchanged");
        wr(0, 8'h50); r_fail = 0; r_volt = 0; r_lock = 0;
        prog(2, 8'h3C, 1, 1, 0, 8'h40, "R9 wp high programs");
        prog(3, 8'h55, 1, 0, 1, 8'h40, "R9 unlock high programs");
        chk_arr(3, "R9 byte via unlock");
        prog(4, 8'h00, 0, 0, 0, 8'h40, "R8 R9 volt precedence");
        wr(0, 8'h50); r_fail = 0; r_volt = 0; r_lock = 0;

        // R5: write during busy ignored
        vpp_ok = 1;
        wr(40, 8'h40);
        wr(40, 8'h3C);
        ref_mem[40] = 8'h3C;
        wr(0, 8'hFF);
        busy_count(n);
        chk_sr("R5 status mode kept after busy write");
        chk_arr(40, "R5 byte after busy write");

        // R5 R10: clear lands on completion cycle
        prog(41, 8'h00, 1, 1, 0, 8'h40, "R5 prep");
        wr(41, 8'h40);
        wr(41, 8'hFF);
        r_fail = 1;
        repeat (PC - 2) @(negedge clk);
        wr(0, 8'h50);
        busy_count(n);
        chk_sr("R5 clear on completion ignored");
        chk_arr(41, "R5 byte committed on completion");
        wr(0, 8'h50); r_fail = 0;
        wr(0, 8'h70);
        chk_sr("R10 clear after completion");

        // R11: unknown code keeps mode
        chk_arr(9, "R11 array mode");
        wr(0, 8'h20);
        rd(9, v); check("R11 unknown code in array mode", v, ref_mem[9]);
        wr(0, 8'h70);
        wr(0, 8'h20);
        chk_sr("R11 unknown code in status mode");

        // random mix
        for (int it = 0; it < 200; it++) begin
            int op;
            logic [AW-1:0] a;
            op = int'($urandom % 4);
            a  = AW'($urandom % DEPTH);
            case (op)
                0: prog(a, 8'($urandom), ($urandom % 8) != 0, 1'($urandom), 1'($urandom),
                        (($urandom % 2) == 0) ? 8'h40 : 8'h10, "R6 random program");
                1: begin
                    wr(0, 8'h50); r_fail = 0; r_volt = 0; r_lock = 0;
                    wr(0, 8'h70);
                    chk_sr("R10 random clear");
                end
                2: chk_arr(a, "R6 random array read");
                default: begin
                    wr(0, 8'h70);
                    chk_sr("R11 random status read");
                end
            endcase
        end
        report();
    end
endmodule